// File: doc/BRIEF.md
# Asynchronous Byte Load Port

This block receives configuration bytes from an external processor that has no clock in common with the chip. The processor selects the port through two chip-select pins of opposite polarity. It presents a byte on an 8-bit bus and pulses an active-low write strobe. The strobe and the bus are brought into the internal clock domain. A byte is accepted when the strobe returns high after having been low. The accepted byte is held in a one-byte buffer and then sent, most significant bit first, to the internal configuration logic on a serial line, with a bit-valid pulse for each bit.

To pace its writes, the processor pulses an active-low read strobe. While that strobe is low and the port is selected, the port drives the bus back to the processor. The top bit carries a Ready/Busy status and the remaining bits are forced high. A write that arrives while a byte is still being shifted is dropped, and a sticky overrun flag records the loss.

Top module: `cfgport_byte_load`

## Requirements
- R1: The port is selected only while `selLowN` is 0 and `selHigh` is 1. A write strobe pulse seen while the port is not selected loads nothing. A read strobe while the port is not selected leaves `busOe` at 0.
- R2: While the port is selected, a byte is accepted on the rising edge of `wrStrobeN` that follows a low period. A single strobe pulse loads exactly one byte, however long it stays low. The value loaded is the one `busIn` holds as the strobe rises.
- R3: While the port is selected, `rdStrobeN` is 0 and `wrStrobeN` is 1, `busOe` is 1 and `busOut[6:0]` is 7'h7F. `busOut[7]` is 1 for Ready and 0 for Busy. In every other case `busOe` is 0.
- R4: While the port is selected and both strobes are low, the write has priority: `busOe` stays 0, and the byte is still accepted when `wrStrobeN` rises.
- R5: The port reports Busy from the cycle in which a byte is captured until its eighth bit has left. After that it reports Ready again.
- R6: Each accepted byte appears on `serData` most significant bit first, one bit per clock. `bitValid` is 1 for exactly 8 consecutive cycles per byte.
- R7: A write that completes while the port is Busy is ignored, so it produces no serial bits. It sets `overrun`, which stays 1 until reset.
- R8: After reset the port is Ready, and `bitValid` and `overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Active-low asynchronous reset |
| selLowN | input | 1 | Chip select, active low |
| selHigh | input | 1 | Chip select, active high |
| wrStrobeN | input | 1 | Write strobe, active low |
| rdStrobeN | input | 1 | Read strobe, active low |
| busIn | input | 8 | Byte from the processor |
| busOut | output | 8 | Read-back status byte |
| busOe | output | 1 | Drive enable for busOut (0 means high impedance) |
| serData | output | 1 | Serial bit to the configuration logic |
| bitValid | output | 1 | Marks a valid bit on serData |
| overrun | output | 1 | Sticky flag for a write dropped while Busy |

## Verification
The assertions assume that `busIn` does not change from the fall of the write strobe until two clocks after its rise. They also assume that each strobe level lasts at least one clock, so that the synchronizer sees every pulse. The stimulus changes pins only on falling clock edges, holds each strobe level for one or more whole cycles, and leaves the bus untouched after a write until the next write begins. Random bytes and random strobe widths are mixed with directed cases: an unselected port, both strobes low together, a long strobe pulse, and a second write landing in the middle of a shift.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic loadHold;   // capture the synchronized bus into the holding byte
    logic loadShift;  // move the holding byte into the shifter
    logic shiftBit;   // present one bit and advance the shifter
  } cfgCtl_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_SHIFT = 2'd2
  } cfgState_t;

endpackage

// File: rtl/cfgport_sync.sv
module cfgport_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= RESET_VAL;
    else       stage[0] <= asyncIn;
  end

  for (genvar g = 1; g < STAGES; g++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[g] <= RESET_VAL;
      else       stage[g] <= stage[g-1];
    end
  end

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/cfgport_ctrl.sv
module cfgport_ctrl
  import cfgport_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    selS,
  input  logic    wsS,
  output cfgCtl_t ctl,
  output logic    busy,
  output logic    overrun
);

  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  cfgState_t         state, stateNext;
  logic [CNT_W-1:0]  bitCnt;
  logic              prevWs, prevSel;
  logic              wrEvent;

  // Rising edge of the write strobe while the low phase was selected
  assign wrEvent = !prevWs && wsS && prevSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevWs  <= 1'b1;
      prevSel <= 1'b0;
    end else begin
      prevWs  <= wsS;
      prevSel <= selS;
    end
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (wrEvent) stateNext = ST_LOAD;
      ST_LOAD:  stateNext = ST_SHIFT;
      ST_SHIFT: if (bitCnt == LAST_BIT) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_SHIFT) bitCnt <= bitCnt + 1'b1;
      else                   bitCnt <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          overrun <= 1'b0;
    else if (wrEvent && state != ST_IDLE) overrun <= 1'b1;
  end

  always_comb begin
    ctl.loadHold  = wrEvent && (state == ST_IDLE);
    ctl.loadShift = (state == ST_LOAD);
    ctl.shiftBit  = (state == ST_SHIFT);
  end

  assign busy = (state != ST_IDLE);

  assert_capture_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadHold |=> ctl.loadShift);

  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);

  assert_busy_ends_after_bit_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(ctl.shiftBit));

  assert_load_then_shift_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadShift |=> ctl.shiftBit);

endmodule

// File: rtl/cfgport_dpath.sv
module cfgport_dpath
  import cfgport_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgCtl_t           ctl,
  input  logic [DATA_W-1:0] dataS,
  input  logic              readEn,
  input  logic              ready,
  output logic [DATA_W-1:0] busOut,
  output logic              serData,
  output logic              bitValid
);

  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg  <= '0;
      shiftReg <= '0;
    end else begin
      if (ctl.loadHold)       holdReg  <= dataS;
      if (ctl.loadShift)      shiftReg <= holdReg;
      else if (ctl.shiftBit)  shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
    end
  end

  assign serData  = shiftReg[DATA_W-1];
  assign bitValid = ctl.shiftBit;

  // Status on the top line, all other lines forced high
  assign busOut = readEn ? {ready, {(DATA_W-1){1'b1}}} : '0;

  assert_msb_first_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.shiftBit && !ctl.loadShift) |=> serData == $past(shiftReg[DATA_W-2]));

  assert_valid_only_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |-> !ready);

endmodule

// File: rtl/cfgport_byte_load.sv
module cfgport_byte_load
  import cfgport_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selLowN,
  input  logic              selHigh,
  input  logic              wrStrobeN,
  input  logic              rdStrobeN,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  output logic              serData,
  output logic              bitValid,
  output logic              overrun
);

  localparam int SYNC_W = DATA_W + 2;

  logic [SYNC_W-1:0] syncIn, syncOut;
  logic              selRaw, selS, wsS, readEn, busy;
  logic [DATA_W-1:0] dataS;
  cfgCtl_t           ctl;

  assign selRaw = !selLowN && selHigh;
  assign syncIn = {selRaw, wrStrobeN, busIn};

  cfgport_sync #(
    .WIDTH(SYNC_W), .STAGES(SYNC_STAGES),
    .RESET_VAL({1'b0, 1'b1, {DATA_W{1'b0}}})
  ) i_sync (
    .clk(clk), .rstN(rstN), .asyncIn(syncIn), .syncOut(syncOut)
  );

  assign {selS, wsS, dataS} = syncOut;

  // Read drive: selected, read low, write high (write wins)
  assign readEn = selRaw && !rdStrobeN && wrStrobeN;
  assign busOe  = readEn;

  cfgport_ctrl #(.DATA_W(DATA_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .selS(selS), .wsS(wsS),
    .ctl(ctl), .busy(busy), .overrun(overrun)
  );

  cfgport_dpath #(.DATA_W(DATA_W)) i_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .dataS(dataS),
    .readEn(readEn), .ready(!busy),
    .busOut(busOut), .serData(serData), .bitValid(bitValid)
  );

  assert_write_priority_R4: assert property (@(posedge clk) disable iff (!rstN)
    !wrStrobeN |-> !busOe);

  assert_unselected_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    (selLowN || !selHigh) |-> !busOe);

endmodule

// File: tb/test_cfgport_byte_load.sv
module test_cfgport_byte_load;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       selLowN = 1'b1, selHigh = 1'b0;
  logic       wrStrobeN = 1'b1, rdStrobeN = 1'b1;
  logic [7:0] busIn = '0;
  logic [7:0] busOut;
  logic       busOe, serData, bitValid, overrun;

  int testsRun = 0;
  int testsFailed = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgport_byte_load i_cfgport_byte_load (
    .clk(clk), .rstN(rstN), .selLowN(selLowN), .selHigh(selHigh),
    .wrStrobeN(wrStrobeN), .rdStrobeN(rdStrobeN), .busIn(busIn),
    .busOut(busOut), .busOe(busOe), .serData(serData),
    .bitValid(bitValid), .overrun(overrun)
  );

  function automatic logic [7:0] statusByte(input logic isReady);
    return {isReady, 7'h7F};
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic selectPort(input logic on);
    selLowN = !on;
    selHigh = on;
  endtask

  task automatic writeByte(input logic [7:0] d, input int holdLow);
    @(negedge clk);
    busIn = d;
    wrStrobeN = 1'b0;
    repeat (holdLow) @(negedge clk);
    wrStrobeN = 1'b1;
  endtask

  // Count bit-valid pulses in a window and collect their bits
  task automatic observe(input int cycles, output int cnt, output logic [7:0] bits,
                         output int span);
    int first = -1, last = -1;
    cnt = 0; bits = '0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (bitValid) begin
        if (first < 0) first = i;
        last = i;
        bits = {bits[6:0], serData};
        cnt++;
      end
    end
    span = (first < 0) ? -1 : last - first;
  endtask

  task automatic readStatus(output logic [7:0] val, output logic oe);
    @(negedge clk);
    rdStrobeN = 1'b0;
    #2;
    val = busOut; oe = busOe;
    @(negedge clk);
    rdStrobeN = 1'b1;
  endtask

  task automatic fullWrite(input logic [7:0] d, input int holdLow, input string req);
    int cnt, span;
    logic [7:0] bits;
    writeByte(d, holdLow);
    observe(24, cnt, bits, span);
    check(cnt == 8, req, cnt, 8);
    check(bits == d, req, bits, d);
    check(span == 7, req, span, 7);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    logic [7:0] val;
    logic oe;
    int cnt, span;
    logic [7:0] bits;
    void'($urandom(32'h1234_5678));

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R8: reset state
    check(bitValid == 1'b0, "R8 bitValid", bitValid, 0);
    check(overrun == 1'b0, "R8 overrun", overrun, 0);
    check(busOe == 1'b0, "R8 busOe idle", busOe, 0);
    selectPort(1'b1);
    readStatus(val, oe);
    check(oe == 1'b1, "R8 R3 read enable", oe, 1);
    check(val == statusByte(1'b1), "R8 ready after reset", val, statusByte(1'b1));

    // R1: unselected write and read
    selectPort(1'b0);
    writeByte(8'hA5, 2);
    observe(24, cnt, bits, span);
    check(cnt == 0, "R1 unselected write (selLowN high)", cnt, 0);
    selLowN = 1'b0; selHigh = 1'b0;
    writeByte(8'h3C, 2);
    observe(24, cnt, bits, span);
    check(cnt == 0, "R1 unselected write (selHigh low)", cnt, 0);
    readStatus(val, oe);
    check(oe == 1'b0, "R1 unselected read", oe, 0);

    // R2/R6: directed bytes
    selectPort(1'b1);
    fullWrite(8'h80, 1, "R6 msb first");
    fullWrite(8'h01, 1, "R6 lsb last");
    fullWrite(8'hC3, 20, "R2 long pulse one byte");

    // R5: busy during shift, ready afterwards
    writeByte(8'h5A, 2);
    repeat (5) @(negedge clk);
    readStatus(val, oe);
    check(oe == 1'b1, "R5 R3 read enable while busy", oe, 1);
    check(val == statusByte(1'b0), "R5 busy status", val, statusByte(1'b0));
    repeat (20) @(negedge clk);
    readStatus(val, oe);
    check(val == statusByte(1'b1), "R5 ready after shift", val, statusByte(1'b1));

    // R4: both strobes low -> write wins
    @(negedge clk);
    busIn = 8'h96;
    wrStrobeN = 1'b0;
    rdStrobeN = 1'b0;
    #2;
    check(busOe == 1'b0, "R4 no read drive", busOe, 0);
    repeat (2) @(negedge clk);
    rdStrobeN = 1'b1;
    @(negedge clk);
    wrStrobeN = 1'b1;
    observe(24, cnt, bits, span);
    check(cnt == 8 && bits == 8'h96, "R4 write accepted", bits, 8'h96);

    // R7: write during busy is dropped
    check(overrun == 1'b0, "R7 no overrun yet", overrun, 0);
    writeByte(8'hE1, 1);
    fork
      observe(24, cnt, bits, span);
      begin
        repeat (3) @(negedge clk);
        busIn = 8'h1E;
        wrStrobeN = 1'b0;
        repeat (2) @(negedge clk);
        wrStrobeN = 1'b1;
      end
    join
    check(cnt == 8, "R7 dropped byte no bits", cnt, 8);
    check(bits == 8'hE1, "R7 first byte intact", bits, 8'hE1);
    check(overrun == 1'b1, "R7 overrun set", overrun, 1);
    fullWrite(8'h42, 2, "R7 normal write after overrun");
    check(overrun == 1'b1, "R7 overrun sticky", overrun, 1);

    // Random bytes and strobe widths
    for (int n = 0; n < 20; n++) begin
      logic [7:0] d;
      int h;
      d = 8'($urandom);
      h = 1 + int'($urandom % 4);
      fullWrite(d, h, "R2 R6 random byte");
    end

    // R8: reset clears overrun
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(overrun == 1'b0, "R8 overrun cleared", overrun, 0);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule